// File: doc/BRIEF.md
# Gamma Correction Lookup Stage

This block sits in a display output path and corrects each colour channel of an 8-bit RGB pixel stream through a 256-entry lookup table. Every table entry holds one corrected value per channel. The red input value indexes the red field of an entry, green indexes green and blue indexes blue, each independently. Pixels leave two clock cycles after they enter. The data-enable and both sync signals travel alongside with the same delay.

A host loads the table through one write-only register. Each 32-bit word carries the target entry number in its top byte and the packed corrected colour below it, so no separate address pointer is needed. A second register holds a single mode bit that selects shadowed updates. With shadowing on, table writes collect in a staging copy and become visible together at the next frame-start pulse. This avoids a frame that shows a half-loaded curve. With shadowing off, a write reaches the active table at once. After reset both copies hold the identity curve, where entry i has value i on every channel.

Top module: `gamma_lut_stage`

## Requirements
- R1: After reset the table is the identity curve, so out_rgb equals the pixel that entered two cycles earlier whenever that pixel had data-enable high.
- R2: A write with reg_addr = 1 targets the table: entry index = reg_wdata[31:24], red = [23:16], green = [15:8], blue = [7:0]. With shadowing off the entry is active for every pixel that reaches the lookup stage after the write edge.
- R3: The output red is the red field of the entry selected by the input red value; green and blue are looked up the same way, each from its own entry (out_rgb packs red [23:16], green [15:8], blue [7:0], and so does pix_rgb).
- R4: A write with reg_addr = 0 loads the shadow-enable flag from reg_wdata[2]; all other bits of that word are ignored. The flag is 0 after reset.
- R5: With shadowing on, a table write does not change the output colours until a frame_start pulse arrives.
- R6: On the first frame_start pulse after one or more staged writes, all staged entries become active together at that clock edge.
- R7: A table write in the same cycle as frame_start, with shadowing on, is not part of that transfer; it becomes active at the following frame_start.
- R8: out_de, out_hs and out_vs equal pix_de, pix_hs and pix_vs delayed by exactly two clock cycles.
- R9: out_rgb is all zeros whenever out_de is low, including during and directly after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the mode register, 1 selects the table register |
| reg_wdata | input | 32 | Register write data |
| frame_start | input | 1 | One-cycle pulse marking the start of a frame |
| pix_de | input | 1 | Input data-enable |
| pix_hs | input | 1 | Input horizontal sync |
| pix_vs | input | 1 | Input vertical sync |
| pix_rgb | input | 24 | Input pixel, red in the top byte |
| out_de | output | 1 | Delayed data-enable |
| out_hs | output | 1 | Delayed horizontal sync |
| out_vs | output | 1 | Delayed vertical sync |
| out_rgb | output | 24 | Corrected pixel, red in the top byte |

## Verification
Random full-range pixels through the identity table show that no channel is lost or shifted. The same pixels through a table loaded with random entries show whether channels are mixed up or indexed by the wrong component. Directed pixels whose three components differ pick three different entries, which separates a correct per-channel lookup from one that uses one index for all channels. Staged writes are checked around frame_start pulses, including a write that lands in the same cycle as the pulse, to tell a held update from an early or lost one. Streams with random data-enable and single sync pulses show the two-cycle alignment and the blanking.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;

  // register select on the host write port
  typedef enum logic {
    GL_REG_CFG   = 1'b0,
    GL_REG_TABLE = 1'b1
  } gl_reg_e;

  // timing signals carried alongside each pixel
  typedef struct packed {
    logic de;
    logic hs;
    logic vs;
  } gl_sync_t;

  localparam int unsigned GL_NUM_CH = 3;

endpackage

// File: rtl/gamma_wr_decode.sv
module gamma_wr_decode
  import gamma_lut_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned IDX_W      = 8,
  parameter int unsigned ENT_W      = 24,
  parameter int unsigned SHADOW_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic              shadow_en,
  output logic              tbl_wr,
  output logic              stage_wr,
  output logic [IDX_W-1:0]  tbl_idx,
  output logic [ENT_W-1:0]  tbl_data
);

  logic shadow_q;
  logic shadow_d;
  logic shadow_ld;
  logic sel_tbl;

  assign sel_tbl   = (reg_addr == GL_REG_TABLE);
  assign shadow_ld = reg_wr && !sel_tbl;

  always_comb begin
    shadow_d = shadow_q;
    if (shadow_ld) begin
      shadow_d = reg_wdata[SHADOW_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= 1'b0;
    end else if (shadow_ld) begin
      shadow_q <= shadow_d;
    end
  end

  assign shadow_en = shadow_q;
  assign tbl_wr    = reg_wr && sel_tbl;
  assign stage_wr  = tbl_wr && shadow_q;
  assign tbl_idx   = reg_wdata[DATA_W-1 -: IDX_W];
  assign tbl_data  = reg_wdata[ENT_W-1:0];

endmodule

// File: rtl/gamma_tbl_store.sv
module gamma_tbl_store
  import gamma_lut_pkg::*;
#(
  parameter int unsigned COMP_W = 8,
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned IDX_W  = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tbl_wr,
  input  logic                         shadow_en,
  input  logic                         stage_wr,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [GL_NUM_CH*COMP_W-1:0]  wr_data,
  input  logic                         frame_start,
  input  logic [IDX_W-1:0]             rd_idx_r,
  input  logic [IDX_W-1:0]             rd_idx_g,
  input  logic [IDX_W-1:0]             rd_idx_b,
  output logic [COMP_W-1:0]            rd_r,
  output logic [COMP_W-1:0]            rd_g,
  output logic [COMP_W-1:0]            rd_b,
  output logic                         pending
);

  localparam int unsigned ENT_W = GL_NUM_CH * COMP_W;

  logic pend_q;
  logic pend_d;
  logic xfer;

  logic [ENT_W-1:0] act_arr [DEPTH];

  assign xfer = frame_start && pend_q;

  // a staged write in the same cycle as the pulse stays pending
  always_comb begin
    pend_d = (pend_q && !frame_start) || stage_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    localparam logic [ENT_W-1:0] RST_VAL = {GL_NUM_CH{COMP_W'(e)}};

    logic             hit;
    logic             direct;
    logic             act_en;
    logic [ENT_W-1:0] act_q;
    logic [ENT_W-1:0] act_d;
    logic [ENT_W-1:0] stg_q;
    logic [ENT_W-1:0] stg_d;

    assign hit    = tbl_wr && (wr_idx == IDX_W'(e));
    assign direct = hit && !shadow_en;
    assign act_en = direct || xfer;

    always_comb begin
      stg_d = stg_q;
      if (hit) begin
        stg_d = wr_data;
      end
    end

    always_comb begin
      act_d = stg_q;
      if (direct) begin
        act_d = wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_q <= RST_VAL;
      end else if (hit) begin
        stg_q <= stg_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_q <= RST_VAL;
      end else if (act_en) begin
        act_q <= act_d;
      end
    end

    assign act_arr[e] = act_q;
  end

  assign rd_r    = act_arr[rd_idx_r][ENT_W-1 -: COMP_W];
  assign rd_g    = act_arr[rd_idx_g][2*COMP_W-1 -: COMP_W];
  assign rd_b    = act_arr[rd_idx_b][COMP_W-1:0];
  assign pending = pend_q;

endmodule

// File: rtl/gamma_pix_pipe.sv
module gamma_pix_pipe
  import gamma_lut_pkg::*;
#(
  parameter int unsigned COMP_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        pix_de,
  input  logic                        pix_hs,
  input  logic                        pix_vs,
  input  logic [GL_NUM_CH*COMP_W-1:0] pix_rgb,
  output logic [COMP_W-1:0]           lk_idx_r,
  output logic [COMP_W-1:0]           lk_idx_g,
  output logic [COMP_W-1:0]           lk_idx_b,
  input  logic [COMP_W-1:0]           lk_r,
  input  logic [COMP_W-1:0]           lk_g,
  input  logic [COMP_W-1:0]           lk_b,
  output logic                        out_de,
  output logic                        out_hs,
  output logic                        out_vs,
  output logic [GL_NUM_CH*COMP_W-1:0] out_rgb
);

  localparam int unsigned PIX_W = GL_NUM_CH * COMP_W;

  gl_sync_t   s1_sync_q, s1_sync_d;
  gl_sync_t   s2_sync_q, s2_sync_d;
  logic [PIX_W-1:0] s1_pix_q, s1_pix_d;
  logic [PIX_W-1:0] s2_pix_q, s2_pix_d;
  logic             s1_pix_en;

  // stage 1: capture; pixel register only loads on active data
  assign s1_pix_en = pix_de;

  always_comb begin
    s1_sync_d.de = pix_de;
    s1_sync_d.hs = pix_hs;
    s1_sync_d.vs = pix_vs;
    s1_pix_d     = pix_rgb;
  end

  assign lk_idx_r = s1_pix_q[PIX_W-1 -: COMP_W];
  assign lk_idx_g = s1_pix_q[2*COMP_W-1 -: COMP_W];
  assign lk_idx_b = s1_pix_q[COMP_W-1:0];

  // stage 2: table result, blanked outside active data
  always_comb begin
    s2_sync_d = s1_sync_q;
    s2_pix_d  = '0;
    if (s1_sync_q.de) begin
      s2_pix_d = {lk_r, lk_g, lk_b};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_sync_q <= '0;
      s2_sync_q <= '0;
      s2_pix_q  <= '0;
    end else begin
      s1_sync_q <= s1_sync_d;
      s2_sync_q <= s2_sync_d;
      s2_pix_q  <= s2_pix_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_pix_q <= '0;
    end else if (s1_pix_en) begin
      s1_pix_q <= s1_pix_d;
    end
  end

  assign out_de  = s2_sync_q.de;
  assign out_hs  = s2_sync_q.hs;
  assign out_vs  = s2_sync_q.vs;
  assign out_rgb = s2_pix_q;

endmodule

// File: rtl/gamma_lut_stage.sv
module gamma_lut_stage
  import gamma_lut_pkg::*;
#(
  parameter int unsigned COMP_W     = 8,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned SHADOW_BIT = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_wr,
  input  logic                        reg_addr,
  input  logic [DATA_W-1:0]           reg_wdata,
  input  logic                        frame_start,
  input  logic                        pix_de,
  input  logic                        pix_hs,
  input  logic                        pix_vs,
  input  logic [GL_NUM_CH*COMP_W-1:0] pix_rgb,
  output logic                        out_de,
  output logic                        out_hs,
  output logic                        out_vs,
  output logic [GL_NUM_CH*COMP_W-1:0] out_rgb
);

  localparam int unsigned IDX_W = COMP_W;
  localparam int unsigned DEPTH = 1 << COMP_W;
  localparam int unsigned ENT_W = GL_NUM_CH * COMP_W;

  logic              shadow_en;
  logic              tbl_wr;
  logic              stage_wr;
  logic              pending;
  logic [IDX_W-1:0]  tbl_idx;
  logic [ENT_W-1:0]  tbl_data;
  logic [COMP_W-1:0] lk_idx_r, lk_idx_g, lk_idx_b;
  logic [COMP_W-1:0] lk_r, lk_g, lk_b;

  gamma_wr_decode #(
    .DATA_W     (DATA_W),
    .IDX_W      (IDX_W),
    .ENT_W      (ENT_W),
    .SHADOW_BIT (SHADOW_BIT)
  ) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .shadow_en (shadow_en),
    .tbl_wr    (tbl_wr),
    .stage_wr  (stage_wr),
    .tbl_idx   (tbl_idx),
    .tbl_data  (tbl_data)
  );

  gamma_tbl_store #(
    .COMP_W (COMP_W),
    .DEPTH  (DEPTH),
    .IDX_W  (IDX_W)
  ) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .tbl_wr      (tbl_wr),
    .shadow_en   (shadow_en),
    .stage_wr    (stage_wr),
    .wr_idx      (tbl_idx),
    .wr_data     (tbl_data),
    .frame_start (frame_start),
    .rd_idx_r    (lk_idx_r),
    .rd_idx_g    (lk_idx_g),
    .rd_idx_b    (lk_idx_b),
    .rd_r        (lk_r),
    .rd_g        (lk_g),
    .rd_b        (lk_b),
    .pending     (pending)
  );

  gamma_pix_pipe #(
    .COMP_W (COMP_W)
  ) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .pix_de   (pix_de),
    .pix_hs   (pix_hs),
    .pix_vs   (pix_vs),
    .pix_rgb  (pix_rgb),
    .lk_idx_r (lk_idx_r),
    .lk_idx_g (lk_idx_g),
    .lk_idx_b (lk_idx_b),
    .lk_r     (lk_r),
    .lk_g     (lk_g),
    .lk_b     (lk_b),
    .out_de   (out_de),
    .out_hs   (out_hs),
    .out_vs   (out_vs),
    .out_rgb  (out_rgb)
  );

endmodule

// File: rtl/gamma_lut_checker.sv
module gamma_lut_checker #(
  parameter int unsigned PIX_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             reg_addr,
  input logic             cfg_bit,
  input logic             frame_start,
  input logic             pix_de,
  input logic             pix_hs,
  input logic             pix_vs,
  input logic             out_de,
  input logic             out_hs,
  input logic             out_vs,
  input logic [PIX_W-1:0] out_rgb,
  input logic             shadow_en,
  input logic             stage_wr,
  input logic             pending
);

  // edges seen since reset release, saturating
  logic [1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 2'd0;
    end else if (seen_q != 2'd3) begin
      seen_q <= seen_q + 2'd1;
    end
  end

  AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q >= 2'd2) |-> (out_de == $past(pix_de, 2)) && (out_hs == $past(pix_hs, 2)) && (out_vs == $past(pix_vs, 2))); // R8

  AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !out_de |-> (out_rgb == '0)); // R9

  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_addr) |=> (shadow_en == $past(cfg_bit))); // R4

  AST_STAGE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    stage_wr |=> pending); // R5

  AST_XFER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && frame_start && !stage_wr) |=> !pending); // R6

  AST_SAME_CYCLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_wr && frame_start) |=> pending); // R7

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !frame_start) |=> pending); // R5

endmodule

bind gamma_lut_stage gamma_lut_checker #(.PIX_W(24)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .cfg_bit     (reg_wdata[2]),
  .frame_start (frame_start),
  .pix_de      (pix_de),
  .pix_hs      (pix_hs),
  .pix_vs      (pix_vs),
  .out_de      (out_de),
  .out_hs      (out_hs),
  .out_vs      (out_vs),
  .out_rgb     (out_rgb),
  .shadow_en   (shadow_en),
  .stage_wr    (stage_wr),
  .pending     (pending)
);

// File: tb/tb_gamma_lut_stage.sv
`timescale 1ns/1ps
module tb_gamma_lut_stage;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic        reg_addr;
  logic [31:0] reg_wdata;
  logic        frame_start;
  logic        pix_de, pix_hs, pix_vs;
  logic [23:0] pix_rgb;
  logic        out_de, out_hs, out_vs;
  logic [23:0] out_rgb;

  int nvec  = 0;
  int nfail = 0;
  bit done  = 1'b0;

  logic [23:0] m_act [256];
  logic [23:0] m_stg [256];
  bit          m_pend;
  bit          m_shadow;

  always #2.5 clk = ~clk;

  gamma_lut_stage dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .frame_start(frame_start),
    .pix_de(pix_de), .pix_hs(pix_hs), .pix_vs(pix_vs), .pix_rgb(pix_rgb),
    .out_de(out_de), .out_hs(out_hs), .out_vs(out_vs), .out_rgb(out_rgb)
  );

  function automatic logic [23:0] exp_px(input logic [23:0] p, input logic de);
    if (!de) return 24'h0;
    return {m_act[p[23:16]][23:16], m_act[p[15:8]][15:8], m_act[p[7:0]][7:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one host cycle: optional write and optional frame_start together
  task automatic bus_cycle(input bit wr, input bit addr, input logic [31:0] d, input bit fs);
    @(negedge clk);
    reg_wr = wr; reg_addr = addr; reg_wdata = d; frame_start = fs;
    @(negedge clk);
    reg_wr = 1'b0; frame_start = 1'b0; reg_wdata = '0;
    if (fs && m_pend) begin
      for (int i = 0; i < 256; i++) m_act[i] = m_stg[i];
    end
    if (wr && !addr) m_shadow = d[2];
    if (wr && addr) begin
      m_stg[d[31:24]] = d[23:0];
      if (!m_shadow) m_act[d[31:24]] = d[23:0];
    end
    m_pend = (m_pend && !fs) || (wr && addr && m_shadow);
  endtask

  task automatic px_once(input logic [23:0] p, input string req);
    logic [23:0] e;
    @(negedge clk);
    pix_de = 1'b1; pix_rgb = p; e = exp_px(p, 1'b1);
    @(negedge clk);
    pix_de = 1'b0; pix_rgb = '0;
    @(negedge clk);
    chk(req, {8'h0, out_rgb}, {8'h0, e});
  endtask

  task automatic stream(input int n, input bit rand_de, input string req);
    logic [23:0] eh [64];
    logic        dh [64];
    for (int i = 0; i < n + 2; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        chk(req, {8'h0, out_rgb}, {8'h0, eh[i-2]});
        chk("R8", {31'h0, out_de}, {31'h0, dh[i-2]});
      end
      if (i < n) begin
        pix_rgb = 24'($urandom);
        pix_de  = rand_de ? 1'($urandom) : 1'b1;
        eh[i] = exp_px(pix_rgb, pix_de);
        dh[i] = pix_de;
      end else begin
        pix_de = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0]  ia, ib;
    logic [23:0] va, vb;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
    frame_start = 1'b0; pix_de = 1'b1; pix_hs = 1'b1; pix_vs = 1'b1;
    pix_rgb = 24'hABCDEF;
    for (int i = 0; i < 256; i++) begin
      m_act[i] = {3{i[7:0]}};
      m_stg[i] = {3{i[7:0]}};
    end
    m_pend = 1'b0; m_shadow = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 reset rgb", {8'h0, out_rgb}, 32'h0);
    chk("R9 reset de", {31'h0, out_de}, 32'h0);
    pix_de = 1'b0; pix_hs = 1'b0; pix_vs = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 after reset", {8'h0, out_rgb}, 32'h0);

    // R1 identity after reset
    px_once(24'h000000, "R1");
    px_once(24'hFFFFFF, "R1");
    stream(40, 1'b0, "R1");

    // R8 single sync pulse
    @(negedge clk); pix_hs = 1'b1; pix_vs = 1'b1;
    @(negedge clk); pix_hs = 1'b0; pix_vs = 1'b0;
    chk("R8 one edge", {30'h0, out_hs, out_vs}, 32'h0);
    @(negedge clk);
    chk("R8 two edges", {30'h0, out_hs, out_vs}, 32'h3);
    @(negedge clk);
    chk("R8 three edges", {30'h0, out_hs, out_vs}, 32'h0);

    // R2 direct writes
    for (int k = 0; k < 20; k++) begin
      ia = 8'($urandom);
      bus_cycle(1'b1, 1'b1, {ia, 24'($urandom)}, 1'b0);
      px_once({ia, ia, ia}, "R2");
    end
    stream(40, 1'b0, "R2");

    // R3 three different indices in one pixel
    bus_cycle(1'b1, 1'b1, {8'h10, 24'h112233}, 1'b0);
    bus_cycle(1'b1, 1'b1, {8'h20, 24'h445566}, 1'b0);
    bus_cycle(1'b1, 1'b1, {8'h30, 24'h778899}, 1'b0);
    px_once(24'h102030, "R3");
    chk("R3 literal", {8'h0, out_rgb}, 32'h00115599);
    px_once(24'h302010, "R3");

    // R4 mode word with bit 2 clear, everything else set: still direct
    bus_cycle(1'b1, 1'b0, 32'hFFFF_FFFB, 1'b0);
    bus_cycle(1'b1, 1'b1, {8'h40, 24'hA0B0C0}, 1'b0);
    px_once(24'h404040, "R4");
    chk("R4 literal", {8'h0, out_rgb}, 32'h00A0B0C0);

    // R5 staged writes held, R6 applied at frame start
    bus_cycle(1'b1, 1'b0, 32'h0000_0004, 1'b0);
    for (int k = 0; k < 10; k++) begin
      bus_cycle(1'b1, 1'b1, {8'(k * 7 + 1), 24'($urandom)}, 1'b0);
    end
    bus_cycle(1'b1, 1'b1, {8'h40, 24'h0F0E0D}, 1'b0);
    px_once(24'h404040, "R5");
    chk("R5 literal", {8'h0, out_rgb}, 32'h00A0B0C0);
    stream(30, 1'b0, "R5");
    bus_cycle(1'b0, 1'b0, 32'h0, 1'b1);
    px_once(24'h404040, "R6");
    chk("R6 literal", {8'h0, out_rgb}, 32'h000F0E0D);
    for (int k = 0; k < 10; k++) px_once({3{8'(k * 7 + 1)}}, "R6");

    // R7 write in the same cycle as frame start
    ia = 8'h55; ib = 8'h66; va = 24'h123456; vb = 24'h654321;
    bus_cycle(1'b1, 1'b1, {ia, va}, 1'b0);
    bus_cycle(1'b1, 1'b1, {ib, vb}, 1'b1);
    px_once({3{ia}}, "R7");
    chk("R7 first applied", {8'h0, out_rgb}, {8'h0, va});
    px_once({3{ib}}, "R7");
    chk("R7 second held", {8'h0, out_rgb}, {8'h0, {3{ib}}});
    bus_cycle(1'b0, 1'b0, 32'h0, 1'b1);
    px_once({3{ib}}, "R7");
    chk("R7 second applied", {8'h0, out_rgb}, {8'h0, vb});

    // R9 random data-enable blanking
    stream(50, 1'b1, "R9");

    // mixed random traffic
    for (int r = 0; r < 30; r++) begin
      case ($urandom % 4)
        0: bus_cycle(1'b1, 1'b0, 32'($urandom), 1'b0);
        1: bus_cycle(1'b0, 1'b0, 32'h0, 1'b1);
        default: bus_cycle(1'b1, 1'b1, 32'($urandom), 1'($urandom));
      endcase
      stream(8, 1'b1, m_shadow ? "R5" : "R2");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule